// File: doc/BRIEF.md
# Received Pause Frame Decoder Timer

This block watches the byte stream of received Ethernet frames and picks out MAC control PAUSE requests. Each byte arrives with a valid strobe. Start-of-frame and end-of-frame markers travel on the first and last valid beats. A CRC verdict from an upstream checker is presented on the last beat. The block does not buffer the header. It compares each header byte against its expected value as the byte arrives. By the end-of-frame beat, it therefore already knows whether the frame is an acceptable PAUSE request.

An accepted request loads a countdown with the 16-bit quanta carried in the frame. The countdown is measured in slot times and is decremented by an external slot-time tick. While the remaining count is non-zero, the block holds a transmit-inhibit output high, which the local transmitter uses to hold off new frames. A one-cycle pulse marks every accepted request, so that a statistics counter can count them.

The request must be addressed to the reserved control multicast address. Optionally, a request addressed to the station's own unicast address is also accepted. Receive flow control can be switched off as a whole.

Top module: `pause_rx_timer`

## Requirements
- R1: A frame is accepted when all of the following hold:
  - its first six bytes (byte 0 carries the start marker) are 01, 80, C2, 00, 00, 01 in that order;
  - the frame is otherwise a valid PAUSE request (R4);
  - the CRC is good (R5);
  - receive flow control is enabled.
- R2: When `cfg_ucast_en` is 1, a frame whose first six bytes equal the station address is also accepted. `cfg_station_addr[47:40]` is the first of those bytes. When `cfg_ucast_en` is 0, such a frame is ignored.
- R3: A frame whose destination is any other value is never accepted, including another multicast address such as 01-80-C2-00-00-02.
- R4: The frame layout must be as follows, and the frame must carry at least 18 bytes:
  - bytes 12 and 13 must be 88 and 08;
  - bytes 14 and 15 must be 00 and 01;
  - bytes 16 and 17 hold the quanta, most significant byte first.
- R5: The countdown is loaded only on the end-of-frame beat, and only if `rx_crc_ok` is 1 on that beat. `pause_left`, `tx_inhibit` and `pause_seen` reflect an accepted frame after the second rising edge that follows the end-of-frame beat.
- R6: A newly accepted frame replaces any remaining count with its own quanta. A quanta of zero therefore ends the inhibit at once.
- R7: While `cfg_rx_fc_en` is 0, no frame is accepted and the count is forced to zero at each clock edge.
- R8: Each edge that samples `slot_tick` high lowers a non-zero count by one. A zero count stays at zero. A load on the same edge as a tick takes precedence, and that tick is lost.
- R9: `tx_inhibit` is 1 exactly when `pause_left` is non-zero.
- R10: `pause_seen` is high for one cycle for each accepted frame.
- R11: Framing rules:
  - only beats with `rx_valid` high advance the frame;
  - a start marker begins a new frame and discards any unfinished one;
  - valid beats outside a frame are ignored, including a stray end marker.
- R12: After reset, `pause_left` is 0, `tx_inhibit` is 0 and `pause_seen` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Byte strobe |
| rx_sof | input | 1 | First beat of a frame |
| rx_eof | input | 1 | Last beat of a frame |
| rx_data | input | 8 | Received byte |
| rx_crc_ok | input | 1 | CRC verdict, sampled on the end beat |
| cfg_rx_fc_en | input | 1 | Enables PAUSE decoding and the countdown |
| cfg_ucast_en | input | 1 | Also accept PAUSE sent to the station address |
| cfg_station_addr | input | 48 | Station unicast address, first byte in bits 47:40 |
| slot_tick | input | 1 | One pulse per slot time |
| tx_inhibit | output | 1 | Transmitter hold-off |
| pause_left | output | 16 | Remaining pause in slot times |
| pause_seen | output | 1 | One-cycle pulse per accepted request |

## Verification
Two events can fall on the same edge: loading the quanta from a just-finished frame, and a slot tick that would decrement the old count. The bench provokes this by raising the tick exactly for the load edge. It then expects the new quanta, undiminished, and expects a decrement only on the next tick. Disabling receive flow control on a cycle where the count is non-zero is the second collision. The bench expects the count to reach zero on the following edge, not to keep counting. A behavioural model, compared on every cycle, judges both collisions alongside the directed checks.

// File: rtl/pause_rx_pkg.sv
package pause_rx_pkg;
  localparam int BYTE_W    = 8;
  localparam int MAC_BYTES = 6;
  localparam int MAC_W     = MAC_BYTES * BYTE_W;
  localparam int QUANTA_W  = 16;

  // reserved destination for MAC control PAUSE requests
  localparam logic [MAC_W-1:0] PAUSE_DA = 48'h0180_C200_0001;

  // length/type followed by opcode, checked as one contiguous field
  localparam int CTL_FIRST = 2 * MAC_BYTES;
  localparam int CTL_BYTES = 4;
  localparam logic [CTL_BYTES*BYTE_W-1:0] CTL_PATTERN = 32'h8808_0001;

  localparam int QNT_FIRST = CTL_FIRST + CTL_BYTES;
  localparam int QNT_BYTES = QUANTA_W / BYTE_W;
  localparam int HDR_LAST  = QNT_FIRST + QNT_BYTES - 1;
  localparam int POS_SAT   = HDR_LAST + 1;
  localparam int POS_W     = $clog2(POS_SAT + 1);
endpackage

// File: rtl/pause_field_cmp.sv
module pause_field_cmp
  import pause_rx_pkg::*;
#(
  parameter int FIRST  = 0,
  parameter int NBYTES = MAC_BYTES
) (
  input  logic [POS_W-1:0]         pos,
  input  logic [BYTE_W-1:0]        data,
  input  logic [NBYTES*BYTE_W-1:0] pattern,
  output logic                     byte_ok
);
  localparam int PW = NBYTES * BYTE_W;

  logic [NBYTES-1:0] hit;

  for (genvar k = 0; k < NBYTES; k++) begin : g_hit
    assign hit[k] = (data == pattern[PW-1-BYTE_W*k -: BYTE_W]);
  end

  // bytes outside this field never spoil the running match
  always_comb begin
    byte_ok = 1'b1;
    for (int k = 0; k < NBYTES; k++) begin
      if (pos == POS_W'(FIRST + k)) byte_ok = hit[k];
    end
  end
endmodule

// File: rtl/pause_hdr_parser.sv
module pause_hdr_parser
  import pause_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                rx_valid,
  input  logic                rx_sof,
  input  logic                rx_eof,
  input  logic [BYTE_W-1:0]   rx_data,
  input  logic                rx_crc_ok,
  input  logic                fc_enable,
  input  logic                ucast_enable,
  input  logic [MAC_W-1:0]    station_addr,
  output logic                pause_ok,
  output logic [QUANTA_W-1:0] pause_quanta
);
  logic                in_frame_q;
  logic [POS_W-1:0]    pos_q;
  logic [POS_W-1:0]    pos_c;
  logic                beat;
  logic                mc_q, uc_q, ctl_q;
  logic                mc_c, uc_c, ctl_c;
  logic                mc_byte_ok, uc_byte_ok, ctl_byte_ok;
  logic [QUANTA_W-1:0] qnt_q, qnt_c;
  logic                long_enough;
  logic                verdict;

  assign beat  = rx_valid & (rx_sof | in_frame_q);
  assign pos_c = rx_sof ? '0 : pos_q;

  pause_field_cmp #(.FIRST(0), .NBYTES(MAC_BYTES)) u_mc_cmp (
    .pos(pos_c), .data(rx_data), .pattern(PAUSE_DA), .byte_ok(mc_byte_ok)
  );

  pause_field_cmp #(.FIRST(0), .NBYTES(MAC_BYTES)) u_uc_cmp (
    .pos(pos_c), .data(rx_data), .pattern(station_addr), .byte_ok(uc_byte_ok)
  );

  pause_field_cmp #(.FIRST(CTL_FIRST), .NBYTES(CTL_BYTES)) u_ctl_cmp (
    .pos(pos_c), .data(rx_data), .pattern(CTL_PATTERN), .byte_ok(ctl_byte_ok)
  );

  always_comb begin
    mc_c  = (rx_sof ? 1'b1 : mc_q)  & mc_byte_ok;
    uc_c  = (rx_sof ? 1'b1 : uc_q)  & uc_byte_ok;
    ctl_c = (rx_sof ? 1'b1 : ctl_q) & ctl_byte_ok;
    qnt_c = qnt_q;
    for (int k = 0; k < QNT_BYTES; k++) begin
      if (pos_c == POS_W'(QNT_FIRST + k))
        qnt_c[QUANTA_W-1-BYTE_W*k -: BYTE_W] = rx_data;
    end
    long_enough = (pos_c >= POS_W'(HDR_LAST));
    verdict = fc_enable & rx_crc_ok & long_enough & ctl_c &
              (mc_c | (ucast_enable & uc_c));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame_q   <= 1'b0;
      pos_q        <= '0;
      mc_q         <= 1'b0;
      uc_q         <= 1'b0;
      ctl_q        <= 1'b0;
      qnt_q        <= '0;
      pause_ok     <= 1'b0;
      pause_quanta <= '0;
    end else begin
      pause_ok <= beat & rx_eof & verdict;
      if (beat) begin
        in_frame_q <= ~rx_eof;
        pos_q      <= (pos_c == POS_W'(POS_SAT)) ? pos_c : pos_c + 1'b1;
        mc_q       <= mc_c;
        uc_q       <= uc_c;
        ctl_q      <= ctl_c;
        qnt_q      <= qnt_c;
        if (rx_eof) pause_quanta <= qnt_c;
      end
    end
  end
endmodule

// File: rtl/pause_quanta_timer.sv
module pause_quanta_timer
  import pause_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                enable,
  input  logic                load,
  input  logic [QUANTA_W-1:0] load_val,
  input  logic                slot_tick,
  output logic [QUANTA_W-1:0] remaining,
  output logic                inhibit,
  output logic                loaded
);
  logic [QUANTA_W-1:0] nxt;

  // priority: disable, then fresh load, then tick
  always_comb begin
    nxt = remaining;
    if (!enable)
      nxt = '0;
    else if (load)
      nxt = load_val;
    else if (slot_tick && (remaining != '0))
      nxt = remaining - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      remaining <= '0;
      inhibit   <= 1'b0;
      loaded    <= 1'b0;
    end else begin
      remaining <= nxt;
      inhibit   <= (nxt != '0);
      loaded    <= load;
    end
  end
endmodule

// File: rtl/pause_rx_timer.sv
module pause_rx_timer
  import pause_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                rx_valid,
  input  logic                rx_sof,
  input  logic                rx_eof,
  input  logic [BYTE_W-1:0]   rx_data,
  input  logic                rx_crc_ok,
  input  logic                cfg_rx_fc_en,
  input  logic                cfg_ucast_en,
  input  logic [MAC_W-1:0]    cfg_station_addr,
  input  logic                slot_tick,
  output logic                tx_inhibit,
  output logic [QUANTA_W-1:0] pause_left,
  output logic                pause_seen
);
  logic                accept_pulse;
  logic [QUANTA_W-1:0] accept_quanta;

  pause_hdr_parser u_parser (
    .clk          (clk),
    .rst          (rst),
    .rx_valid     (rx_valid),
    .rx_sof       (rx_sof),
    .rx_eof       (rx_eof),
    .rx_data      (rx_data),
    .rx_crc_ok    (rx_crc_ok),
    .fc_enable    (cfg_rx_fc_en),
    .ucast_enable (cfg_ucast_en),
    .station_addr (cfg_station_addr),
    .pause_ok     (accept_pulse),
    .pause_quanta (accept_quanta)
  );

  pause_quanta_timer u_timer (
    .clk       (clk),
    .rst       (rst),
    .enable    (cfg_rx_fc_en),
    .load      (accept_pulse),
    .load_val  (accept_quanta),
    .slot_tick (slot_tick),
    .remaining (pause_left),
    .inhibit   (tx_inhibit),
    .loaded    (pause_seen)
  );
endmodule

// File: rtl/pause_rx_timer_chk.sv
module pause_rx_timer_chk
  import pause_rx_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic                cfg_rx_fc_en,
  input logic                slot_tick,
  input logic                ld,
  input logic                tx_inhibit,
  input logic [QUANTA_W-1:0] pause_left,
  input logic                pause_seen
);
  assert_inhibit_tracks_count_R9: assert property (@(posedge clk) disable iff (rst)
    tx_inhibit == (pause_left != '0));

  assert_pulse_isolated_R10: assert property (@(posedge clk) disable iff (rst)
    pause_seen |=> !pause_seen);

  assert_load_flags_R10: assert property (@(posedge clk) disable iff (rst)
    ld |=> pause_seen);

  assert_disable_clears_R7: assert property (@(posedge clk) disable iff (rst)
    !cfg_rx_fc_en |=> (pause_left == '0));

  assert_tick_step_R8: assert property (@(posedge clk) disable iff (rst)
    (cfg_rx_fc_en && !ld && slot_tick && (pause_left != '0)) |=>
      (pause_left == $past(pause_left) - 1'b1));

  assert_no_growth_R8: assert property (@(posedge clk) disable iff (rst)
    !ld |=> (pause_left <= $past(pause_left)));
endmodule

bind pause_rx_timer pause_rx_timer_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .cfg_rx_fc_en (cfg_rx_fc_en),
  .slot_tick    (slot_tick),
  .ld           (accept_pulse),
  .tx_inhibit   (tx_inhibit),
  .pause_left   (pause_left),
  .pause_seen   (pause_seen)
);

// File: tb/pause_rx_timer_test.sv
`timescale 1ns/1ps
module pause_rx_timer_test;
  typedef logic [7:0] bq_t[$];

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, rx_crc_ok = 1'b0;
  logic [7:0]  rx_data = 8'h00;
  logic        cfg_rx_fc_en = 1'b1, cfg_ucast_en = 1'b0;
  logic [47:0] cfg_station_addr = 48'h0211_2233_4455;
  logic        slot_tick = 1'b0;
  logic        tx_inhibit;
  logic [15:0] pause_left;
  logic        pause_seen;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  localparam logic [47:0] MC = 48'h0180_C200_0001;

  pause_rx_timer uut (.*);

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_bytes[$];
  bit m_in = 0, m_pend = 0, m_pulse = 0;
  int m_pend_q = 0, m_cnt = 0;

  function automatic bit m_decide();
    logic [47:0] da;
    if (m_bytes.size() < 18) return 0;
    if (!rx_crc_ok || !cfg_rx_fc_en) return 0;
    if ({m_bytes[12], m_bytes[13]} != 16'h8808) return 0;
    if ({m_bytes[14], m_bytes[15]} != 16'h0001) return 0;
    da = {m_bytes[0], m_bytes[1], m_bytes[2], m_bytes[3], m_bytes[4], m_bytes[5]};
    return (da == MC) || (cfg_ucast_en && da == cfg_station_addr);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_in = 0; m_pend = 0; m_pulse = 0; m_cnt = 0; m_pend_q = 0;
    end else begin
      m_pulse = m_pend;
      if (!cfg_rx_fc_en) m_cnt = 0;
      else if (m_pend) m_cnt = m_pend_q;
      else if (slot_tick && m_cnt != 0) m_cnt = m_cnt - 1;
      m_pend = 0;
      if (rx_valid && (rx_sof || m_in)) begin
        if (rx_sof) begin m_bytes.delete(); m_in = 1; end
        m_bytes.push_back(rx_data);
        if (rx_eof) begin
          m_in = 0;
          m_pend = m_decide();
          m_pend_q = {m_bytes[16], m_bytes[17]};
        end
      end
    end
  end

  always @(negedge clk) if (!done) begin
    check(int'(pause_left) == m_cnt, "R8 model count", int'(pause_left), m_cnt);
    check(tx_inhibit == (m_cnt != 0), "R9 model inhibit", int'(tx_inhibit), int'(m_cnt != 0));
    check(pause_seen == m_pulse, "R10 model pulse", int'(pause_seen), int'(m_pulse));
  end

  // ---------------- stimulus helpers ----------------
  function automatic bq_t build(input logic [47:0] da, input logic [15:0] typ,
                                input logic [15:0] op, input logic [15:0] q, input int len);
    bq_t f;
    for (int i = 0; i < 6; i++) f.push_back(da[47-8*i -: 8]);
    for (int i = 0; i < 6; i++) f.push_back(8'h0A + 8'(i));
    f.push_back(typ[15:8]); f.push_back(typ[7:0]);
    f.push_back(op[15:8]);  f.push_back(op[7:0]);
    f.push_back(q[15:8]);   f.push_back(q[7:0]);
    while (f.size() < len) f.push_back(8'h00);
    while (f.size() > len) void'(f.pop_back());
    return f;
  endfunction

  task automatic idle_beat();
    rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_crc_ok = 0; rx_data = 8'h01;
  endtask

  task automatic send(input bq_t f, input bit crc, input bit gaps, input bit close);
    for (int i = 0; i < f.size(); i++) begin
      @(negedge clk);
      rx_valid = 1; rx_sof = (i == 0); rx_data = f[i];
      rx_eof = close && (i == f.size() - 1);
      rx_crc_ok = crc && rx_eof;
      if (gaps && (i % 3 == 1)) begin
        @(negedge clk);
        idle_beat();
      end
    end
    @(negedge clk);
    idle_beat();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); slot_tick = 1;
    end
    @(negedge clk); slot_tick = 0;
  endtask

  task automatic expect_left(input int exp, input string tag);
    check(int'(pause_left) == exp, tag, int'(pause_left), exp);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL R12 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  // ---------------- directed sequence ----------------
  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    check(pause_left == 0 && !tx_inhibit && !pause_seen, "R12 reset state",
          int'({pause_left, tx_inhibit, pause_seen}), 0);

    // R1 R5 R10: reserved multicast, two-edge latency
    send(build(MC, 16'h8808, 16'h0001, 16'h0123, 18), 1, 0, 1);
    expect_left(0, "R5 not yet loaded");
    @(negedge clk);
    expect_left('h123, "R1 multicast accepted");
    check(pause_seen == 1, "R10 pulse", int'(pause_seen), 1);
    check(tx_inhibit == 1, "R9 inhibit high", int'(tx_inhibit), 1);
    @(negedge clk);
    check(pause_seen == 0, "R10 pulse single", int'(pause_seen), 0);

    ticks(3);
    expect_left('h120, "R8 three ticks");

    // R2: unicast gated by enable
    send(build(cfg_station_addr, 16'h8808, 16'h0001, 16'h0050, 18), 1, 0, 1);
    @(negedge clk);
    expect_left('h120, "R2 unicast ignored when off");
    cfg_ucast_en = 1;
    send(build(cfg_station_addr, 16'h8808, 16'h0001, 16'h0050, 18), 1, 0, 1);
    @(negedge clk);
    expect_left('h50, "R2 unicast accepted, R6 reload");

    // R3 other multicast
    send(build(48'h0180_C200_0002, 16'h8808, 16'h0001, 16'h0999, 18), 1, 0, 1);
    @(negedge clk);
    expect_left('h50, "R3 other multicast");

    // R5 bad CRC
    send(build(MC, 16'h8808, 16'h0001, 16'h0777, 18), 0, 0, 1);
    @(negedge clk);
    expect_left('h50, "R5 bad crc");

    // R4 wrong type, wrong opcode, short, padded
    send(build(MC, 16'h8809, 16'h0001, 16'h0777, 18), 1, 0, 1);
    @(negedge clk);
    expect_left('h50, "R4 wrong type");
    send(build(MC, 16'h8808, 16'h0002, 16'h0777, 18), 1, 0, 1);
    @(negedge clk);
    expect_left('h50, "R4 wrong opcode");
    send(build(MC, 16'h8808, 16'h0001, 16'h0777, 17), 1, 0, 1);
    @(negedge clk);
    expect_left('h50, "R4 short frame");
    send(build(MC, 16'h8808, 16'h0001, 16'h0044, 46), 1, 0, 1);
    @(negedge clk);
    expect_left('h44, "R4 padded frame");

    // R11 gaps, restart, stray end marker
    send(build(MC, 16'h8808, 16'h0001, 16'h0033, 18), 1, 1, 1);
    @(negedge clk);
    expect_left('h33, "R11 gaps");
    send(build(48'hFFFF_FFFF_FFFF, 16'h0800, 16'h0000, 16'h0000, 5), 1, 0, 0);
    send(build(MC, 16'h8808, 16'h0001, 16'h0022, 18), 1, 0, 1);
    @(negedge clk);
    expect_left('h22, "R11 restart");
    @(negedge clk);
    rx_valid = 1; rx_eof = 1; rx_crc_ok = 1; rx_data = 8'h00;
    @(negedge clk);
    idle_beat();
    repeat (2) @(negedge clk);
    expect_left('h22, "R11 stray end");

    // R8 tick coincident with load
    send(build(MC, 16'h8808, 16'h0001, 16'h0010, 18), 1, 0, 1);
    slot_tick = 1;
    @(negedge clk);
    slot_tick = 0;
    expect_left('h10, "R8 load beats tick");
    ticks(1);
    expect_left('h0F, "R8 tick after load");

    // R6 zero quanta
    send(build(MC, 16'h8808, 16'h0001, 16'h0000, 18), 1, 0, 1);
    @(negedge clk);
    expect_left(0, "R6 zero quanta");
    check(tx_inhibit == 0, "R9 inhibit low", int'(tx_inhibit), 0);

    // R8 floor at zero
    send(build(MC, 16'h8808, 16'h0001, 16'h0002, 18), 1, 0, 1);
    @(negedge clk);
    ticks(4);
    expect_left(0, "R8 no wrap");
    check(tx_inhibit == 0, "R9 inhibit released", int'(tx_inhibit), 0);

    // R7 disable clears and blocks
    send(build(MC, 16'h8808, 16'h0001, 16'h0040, 18), 1, 0, 1);
    @(negedge clk);
    expect_left('h40, "R7 loaded before disable");
    cfg_rx_fc_en = 0;
    @(negedge clk);
    expect_left(0, "R7 disable clears");
    send(build(MC, 16'h8808, 16'h0001, 16'h0040, 18), 1, 0, 1);
    @(negedge clk);
    expect_left(0, "R7 disabled ignores");
    cfg_rx_fc_en = 1;
    repeat (3) @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule